// File: doc/BRIEF.md
# Speculative Transaction Conflict Tracker

This block follows the memory footprint of one speculative transaction on a core. It keeps two small tables of cache-line tags. The read table holds the lines the core has loaded and the write table holds the lines it has stored, both since the transaction began. Each address is cut down to its 64-byte line number before any comparison. While a transaction is open, the block compares every coherence snoop from other cores against both tables. It raises an abort when a remote access would break isolation, when a table has no room for a new line, when an external interrupt arrives, or when software asks for an abort.

A command port opens a transaction, commits it or aborts it. A commit gives a one-cycle commit pulse. Any abort gives a one-cycle abort pulse together with a 3-bit reason. Both commit and abort empty the two tables, so the next transaction starts with nothing tracked. Local accesses and snoops that arrive while no transaction is open leave no trace. The data cache, the coherence engine and register checkpointing sit outside this block and react to the pulses.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset, `active`, `abort_pulse` and `commit_pulse` are low and `abort_reason` is 0.
- R2: `cmd_op` = 1 (begin) while inactive sets `active` one cycle later. `cmd_op` = 2 (end) while active gives `commit_pulse` high for exactly one cycle and clears `active`.
- R3: Addresses are compared by line number (address bits above the low 6). Two addresses inside the same 64-byte line are the same line, and addresses in different lines never match.
- R4: While active, a remote write to a line in the read table or the write table, or a remote read of a line in the write table, aborts with reason 1 (conflict) on the next cycle.
- R5: A remote read of a line that is only in the read table, and any snoop to an untracked line, causes no abort.
- R6: A local read of a new line when all 16 read entries are in use aborts with reason 2. Re-reading a line that is already tracked takes no new entry and never overflows.
- R7: A local write of a new line when all 16 write entries are in use aborts with reason 3. Rewriting a tracked line never overflows.
- R8: `ext_irq` high while active aborts with reason 4. `ext_irq` while inactive has no effect.
- R9: `cmd_op` = 3 while active aborts with reason 5. An end command in the same cycle as an abort cause yields the abort and no commit.
- R10: Commit and abort both invalidate every tracked line. A later transaction does not conflict on lines the earlier one touched.
- R11: Local accesses and snoops while inactive are ignored: they fill no entry and cause no pulse.
- R12: When several abort causes coincide, the reported reason follows the order conflict, interrupt, read overflow, write overflow, software abort.
- R13: `abort_pulse` lasts one cycle. `abort_reason` is 0 whenever `abort_pulse` is low. `abort_pulse` and `commit_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 begin, 2 end, 3 abort |
| acc_valid | input | 1 | Local access strobe |
| acc_write | input | 1 | Local access is a store |
| acc_addr | input | ADDR_W | Local byte address |
| snp_valid | input | 1 | Remote snoop strobe |
| snp_write | input | 1 | Snoop is a remote write |
| snp_addr | input | ADDR_W | Remote byte address |
| ext_irq | input | 1 | External interruption |
| active | output | 1 | Transaction open |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_reason | output | 3 | 1 conflict, 2 read full, 3 write full, 4 interrupt, 5 software |
| commit_pulse | output | 1 | One-cycle commit indication |

## Verification
The bench sweeps every pairing of local and remote access kind, each on the same line at another byte offset and on the neighbouring line. A design that tested whole addresses would miss a same-line conflict. A design that treated a remote read of a read-only line as a conflict would abort on a read-after-read, which is harmless. Both tables are filled to exactly 16 lines and then re-touched with shifted offsets, so a tracker that spent an entry on a repeat access overflows too early. Transactions are also started after aborts and commits on lines the earlier transaction used, which catches tables that were not emptied. Finally, causes are stacked in one cycle to expose a wrong priority order.

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int RD_DEPTH   = 16,
  parameter int WR_DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              ext_irq,
  output logic              active,
  output logic              abort_pulse,
  output logic [2:0]        abort_reason,
  output logic              commit_pulse
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int RD_IW = $clog2(RD_DEPTH);
  localparam int WR_IW = $clog2(WR_DEPTH);
  localparam logic [1:0] OP_BEGIN = 2'd1, OP_END = 2'd2, OP_ABORT = 2'd3;
  localparam logic [2:0] WHY_CONFLICT = 3'd1, WHY_RD_FULL = 3'd2, WHY_WR_FULL = 3'd3,
                         WHY_IRQ = 3'd4, WHY_SW = 3'd5;

  logic [TAG_W-1:0]    rd_tag [RD_DEPTH];
  logic [TAG_W-1:0]    wr_tag [WR_DEPTH];
  logic [RD_DEPTH-1:0] rd_vld;
  logic [WR_DEPTH-1:0] wr_vld;

  wire [TAG_W-1:0] acc_line = acc_addr[ADDR_W-1:OFS_W];
  wire [TAG_W-1:0] snp_line = snp_addr[ADDR_W-1:OFS_W];

  logic rd_hit_a, wr_hit_a, rd_hit_s, wr_hit_s;
  logic [RD_IW-1:0] rd_free;
  logic [WR_IW-1:0] wr_free;

  always_comb begin
    rd_hit_a = 1'b0;
    rd_hit_s = 1'b0;
    rd_free  = '0;
    for (int i = RD_DEPTH - 1; i >= 0; i--) begin
      if (rd_vld[i] && rd_tag[i] == acc_line) rd_hit_a = 1'b1;
      if (rd_vld[i] && rd_tag[i] == snp_line) rd_hit_s = 1'b1;
      if (!rd_vld[i]) rd_free = RD_IW'(i);
    end
  end

  always_comb begin
    wr_hit_a = 1'b0;
    wr_hit_s = 1'b0;
    wr_free  = '0;
    for (int i = WR_DEPTH - 1; i >= 0; i--) begin
      if (wr_vld[i] && wr_tag[i] == acc_line) wr_hit_a = 1'b1;
      if (wr_vld[i] && wr_tag[i] == snp_line) wr_hit_s = 1'b1;
      if (!wr_vld[i]) wr_free = WR_IW'(i);
    end
  end

  wire rd_new   = active && acc_valid && !acc_write && !rd_hit_a;
  wire wr_new   = active && acc_valid &&  acc_write && !wr_hit_a;
  wire rd_ovf   = rd_new && (&rd_vld);
  wire wr_ovf   = wr_new && (&wr_vld);
  wire conflict = active && snp_valid && (wr_hit_s || (snp_write && rd_hit_s));
  wire irq      = active && ext_irq;
  wire sw_abort = active && cmd_valid && cmd_op == OP_ABORT;
  wire fail     = conflict || irq || rd_ovf || wr_ovf || sw_abort;
  wire done     = active && cmd_valid && cmd_op == OP_END && !fail;
  wire start    = !active && cmd_valid && cmd_op == OP_BEGIN;

  logic [2:0] why;
  always_comb begin
    if (conflict)    why = WHY_CONFLICT;
    else if (irq)    why = WHY_IRQ;
    else if (rd_ovf) why = WHY_RD_FULL;
    else if (wr_ovf) why = WHY_WR_FULL;
    else             why = WHY_SW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      abort_pulse  <= 1'b0;
      commit_pulse <= 1'b0;
      abort_reason <= '0;
      rd_vld       <= '0;
      wr_vld       <= '0;
    end else begin
      abort_pulse  <= fail;
      commit_pulse <= done;
      abort_reason <= fail ? why : 3'd0;
      if (fail || done) begin
        active <= 1'b0;
        rd_vld <= '0;
        wr_vld <= '0;
      end else begin
        if (start) active <= 1'b1;
        if (rd_new) begin
          rd_vld[rd_free] <= 1'b1;
          rd_tag[rd_free] <= acc_line;
        end
        if (wr_new) begin
          wr_vld[wr_free] <= 1'b1;
          wr_tag[wr_free] <= acc_line;
        end
      end
    end
  end

  a_r13_exclusive_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_pulse && commit_pulse));
  a_r13_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
  a_r13_reason_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_pulse |-> abort_reason == 3'd0);
  a_r10_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse || commit_pulse) |-> (!active && rd_vld == '0 && wr_vld == '0));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!abort_pulse && !commit_pulse));
  a_r4_snoop_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (active && snp_valid && snp_write && (rd_hit_s || wr_hit_s))
      |=> (abort_pulse && abort_reason == WHY_CONFLICT));
  a_r8_irq_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ext_irq) |=> abort_pulse);
  a_r6_no_entry_growth_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (rd_vld == '0 && wr_vld == '0));
endmodule

// File: tb/txn_conflict_tracker_test.sv
module txn_conflict_tracker_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [31:0] acc_addr = 0;
  logic snp_valid = 0, snp_write = 0;
  logic [31:0] snp_addr = 0;
  logic ext_irq = 0;
  logic active, abort_pulse, commit_pulse;
  logic [2:0] abort_reason;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txn_conflict_tracker uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .ext_irq(ext_irq), .active(active), .abort_pulse(abort_pulse),
    .abort_reason(abort_reason), .commit_pulse(commit_pulse));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    cmd_valid = 0; acc_valid = 0; snp_valid = 0; ext_irq = 0;
  endtask

  task automatic cmd(input logic [1:0] op);
    cmd_valid = 1; cmd_op = op; tick();
  endtask

  task automatic acc(input bit w, input int a);
    acc_valid = 1; acc_write = w; acc_addr = 32'(a); tick();
  endtask

  task automatic snp(input bit w, input int a);
    snp_valid = 1; snp_write = w; snp_addr = 32'(a); tick();
  endtask

  task automatic expect_abort(input string tag, input int why);
    chk(abort_pulse == 1'b1 && abort_reason == 3'(why), tag, abort_reason, why);
    chk(active == 1'b0, {tag, " inactive"}, active, 0);
  endtask

  task automatic expect_quiet(input string tag);
    chk(abort_pulse == 1'b0, tag, abort_pulse, 0);
  endtask

  task automatic close_if_open();
    if (active) cmd(2'd2);
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk(!active && !abort_pulse && !commit_pulse && abort_reason == 0, "R1 reset", active, 0);
    rst_n = 1;
    tick();

    // R2 begin and commit
    cmd(2'd1);
    chk(active == 1, "R2 begin", active, 1);
    cmd(2'd2);
    chk(commit_pulse == 1 && active == 0, "R2 commit", commit_pulse, 1);
    tick();
    chk(commit_pulse == 0, "R2 commit single cycle", commit_pulse, 0);

    // R3 R4 R5 sweep of local kind, remote kind, same or other line
    for (int lk = 0; lk < 2; lk++)
      for (int rk = 0; rk < 2; rk++)
        for (int same = 0; same < 2; same++) begin
          int base = 64 * (5 + lk * 4 + rk * 2);
          cmd(2'd1);
          acc(bit'(lk), base + 3);
          snp(bit'(rk), same ? base + 37 : base + 64 + 3);
          if (same && (lk == 1 || rk == 1))
            expect_abort("R4 conflict", 1);
          else if (same)
            expect_quiet("R5 read after read");
          else
            expect_quiet("R3 other line");
          close_if_open();
        end

    // R6 read table fills to 16, repeats take no entry, then overflow
    cmd(2'd1);
    for (int i = 0; i < 16; i++) acc(0, i * 64);
    for (int i = 0; i < 16; i++) begin
      acc(0, i * 64 + 63);
      if (i == 15) expect_quiet("R6 repeat read");
    end
    chk(active == 1, "R6 still open", active, 1);
    acc(0, 16 * 64);
    expect_abort("R6 read overflow", 2);
    tick();
    chk(abort_pulse == 0 && abort_reason == 0, "R13 pulse width", abort_pulse, 0);

    // R10 table cleared after abort
    cmd(2'd1);
    snp(1, 0);
    expect_quiet("R10 cleared after abort");
    close_if_open();

    // R7 write table
    cmd(2'd1);
    for (int i = 0; i < 16; i++) acc(1, 4096 + i * 64);
    for (int i = 0; i < 16; i++) acc(1, 4096 + i * 64 + 8);
    chk(active == 1 && abort_pulse == 0, "R7 repeat write", active, 1);
    acc(1, 4096 + 16 * 64);
    expect_abort("R7 write overflow", 3);
    tick();

    // R10 cleared after commit
    cmd(2'd1);
    acc(1, 640);
    cmd(2'd2);
    chk(commit_pulse == 1, "R10 commit", commit_pulse, 1);
    cmd(2'd1);
    snp(1, 640);
    expect_quiet("R10 cleared after commit");
    close_if_open();

    // R8 interrupt
    ext_irq = 1; tick();
    expect_quiet("R8 irq idle");
    chk(active == 0, "R8 irq idle stays closed", active, 0);
    cmd(2'd1);
    ext_irq = 1; tick();
    expect_abort("R8 irq", 4);
    tick();

    // R11 idle accesses ignored
    acc(1, 1280);
    acc(0, 1344);
    snp(1, 1280);
    expect_quiet("R11 idle snoop");
    cmd(2'd1);
    snp(1, 1280);
    expect_quiet("R11 idle write not tracked");
    snp(1, 1344);
    expect_quiet("R11 idle read not tracked");
    close_if_open();

    // R9 software abort, and end colliding with an abort cause
    cmd(2'd1);
    cmd(2'd3);
    expect_abort("R9 software abort", 5);
    chk(commit_pulse == 0, "R9 no commit", commit_pulse, 0);
    tick();
    cmd(2'd1);
    ext_irq = 1; cmd(2'd2);
    expect_abort("R9 end loses to irq", 4);
    chk(commit_pulse == 0, "R13 exclusive", commit_pulse, 0);
    tick();

    // R12 priorities
    cmd(2'd1);
    for (int i = 0; i < 16; i++) acc(0, i * 64);
    acc_valid = 1; acc_write = 0; acc_addr = 32'(100 * 64);
    snp_valid = 1; snp_write = 1; snp_addr = 32'(0);
    ext_irq = 1; cmd_valid = 1; cmd_op = 2'd3;
    tick();
    expect_abort("R12 conflict first", 1);
    tick();
    cmd(2'd1);
    for (int i = 0; i < 16; i++) acc(0, i * 64);
    acc_valid = 1; acc_write = 0; acc_addr = 32'(100 * 64);
    ext_irq = 1;
    tick();
    expect_abort("R12 irq over overflow", 4);
    tick();
    cmd(2'd1);
    for (int i = 0; i < 16; i++) acc(0, i * 64);
    acc_valid = 1; acc_write = 0; acc_addr = 32'(100 * 64);
    cmd_valid = 1; cmd_op = 2'd3;
    tick();
    expect_abort("R12 overflow over software", 2);
    tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule